// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back data cache whose main store is direct-mapped, so a hit is one tag compare and one read. Next to it sits a small fully associative buffer that catches every valid line thrown out of the main store. When a request misses in the main store, the buffer is searched in the same cycle. On a buffer hit, the two lines trade places in one extra cycle, and no memory traffic is needed. Only a miss in both places goes to the next level.

The processor side accepts one request at a time through a valid/ready pair and answers with a one-cycle response pulse. The next-level side moves whole lines. A request is held until a one-cycle acknowledge arrives. Read data comes with that acknowledge, and write data is held on the port while the request is pending. The default geometry is 4 KB in 256 sets of 16-byte lines, with a 4-entry buffer. Each buffer entry holds a full block address, because a line from any set can land in it.

Top module: `victim_cache`

## Requirements
- R1: After reset, req_ready_o is 1 and resp_valid_o and mem_req_o are 0. All lines are invalid, so the first access misses.
- R2: Address fields are as follows. Bits [3:2] select the word, bits [11:4] the set, and bits [31:12] form the tag. The block address is bits [31:4]. A read that hits the main store gives resp_valid_o with the word in the cycle after acceptance, and no memory request is made.
- R3: A write that hits replaces the addressed word and marks the line dirty. It is answered in the cycle after acceptance, and a later read returns the new word.
- R4: A miss in both places issues a read of the block address on the memory port. The response comes in the cycle after the read acknowledge, and the refilled line then holds the requested word.
- R5: A valid line displaced from the main store moves into the victim buffer with no memory write at that time. A later access to it is served from the buffer.
- R6: A victim hit is answered exactly two cycles after acceptance, with no memory traffic. The requested line moves to the main store, and the line it displaces takes over the same buffer entry.
- R7: When all buffer entries are valid, an insertion pushes out the entry inserted earliest. A later access to that block misses to memory.
- R8: A dirty entry that is pushed out is written to memory with its block address and line. That write is acknowledged before the refill read is issued. A clean entry that is pushed out is not written.
- R9: While mem_req_o is high and no acknowledge has arrived, mem_req_o, mem_we_o and mem_blk_o stay unchanged.
- R10: A block is never present in the main store and the buffer at the same time, and it occupies at most one buffer entry.
- R11: req_ready_o is 0 from the cycle after a non-hit request is accepted until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Cache can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (32) | Byte address |
| req_wdata_i | input | DATA_W (32) | Write word |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | DATA_W (32) | Read word (valid for reads) |
| mem_req_o | output | 1 | Next-level request |
| mem_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_blk_o | output | BLK_W (28) | Block address of the transfer |
| mem_wdata_o | output | LINE_W (128) | Line being written back |
| mem_ack_i | input | 1 | One-cycle transfer acknowledge |
| mem_rdata_i | input | LINE_W (128) | Refill line, valid with acknowledge |

## Verification
Wrong internal state shows up at the ports in a few ways. A corrupted valid or tag bit turns into a response that arrives one, two or several cycles away from the expected latency on the very next access to that block. A lost or duplicated victim entry turns a two-cycle buffer hit into a full memory round trip, or makes a stale word come back. A wrong FIFO position or a wrong dirty bit shows on the memory port as a write-back that is missing, extra, or aimed at the wrong block. It appears during the refill that pushes the entry out, which can be several misses after the fault. Comparing latency, read word and every memory transfer against a behavioural model therefore exposes a fault within one access of its first effect.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWAP,
    ST_WB,
    ST_FILL
  } vc_state_e;
endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              wr_dirty_i
);
  logic [SETS-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = line_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      line_q[idx_i] <= wr_line_i;
    end
  end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned BLK_W   = 28,
  parameter int unsigned LINE_W  = 128,
  localparam int unsigned WAY_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  look_blk_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [LINE_W-1:0] hit_line_o,
  output logic              hit_dirty_o,
  output logic [WAY_W-1:0]  ptr_way_o,
  output logic              ptr_valid_o,
  output logic              ptr_dirty_o,
  output logic [BLK_W-1:0]  ptr_blk_o,
  output logic [LINE_W-1:0] ptr_line_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic [BLK_W-1:0]  wr_blk_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              push_i
);
  logic [ENTRIES-1:0] valid_q, dirty_q, match;
  logic [BLK_W-1:0]   blk_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [WAY_W-1:0]   ptr_q;

  // one comparator per entry, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (blk_q[g] == look_blk_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_way_o = WAY_W'(i);
    end
  end

  assign hit_o       = |match;
  assign hit_line_o  = line_q[hit_way_o];
  assign hit_dirty_o = dirty_q[hit_way_o];
  assign ptr_way_o   = ptr_q;
  assign ptr_valid_o = valid_q[ptr_q];
  assign ptr_dirty_o = dirty_q[ptr_q];
  assign ptr_blk_o   = blk_q[ptr_q];
  assign ptr_line_o  = line_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (wr_en_i) begin
        valid_q[wr_way_i] <= wr_valid_i;
        dirty_q[wr_way_i] <= wr_dirty_i;
      end
      if (push_i) ptr_q <= (ptr_q == WAY_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      blk_q[wr_way_i]  <= wr_blk_i;
      line_q[wr_way_i] <= wr_line_i;
    end
  end

  AST_VB_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R10
  AST_VB_PUSH_AT_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (wr_en_i && wr_way_i == ptr_q)); // R7
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned SETS       = 256,
  parameter int unsigned VB_ENTRIES = 4,
  localparam int unsigned LINE_W = DATA_W * LINE_WORDS,
  localparam int unsigned OFF_W  = $clog2(LINE_W / 8),
  localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
  localparam int unsigned WSEL_W = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned BLK_W  = ADDR_W - OFF_W,
  localparam int unsigned TAG_W  = BLK_W - IDX_W,
  localparam int unsigned WAY_W  = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_blk_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  vc_state_e st_q, st_d;
  logic              q_we;
  logic [BLK_W-1:0]  q_blk;
  logic [WSEL_W-1:0] q_word;
  logic [DATA_W-1:0] q_wdata;

  logic [BLK_W-1:0]  req_blk, look_blk;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              cur_we;
  logic [WSEL_W-1:0] cur_word;
  logic [DATA_W-1:0] cur_wdata;
  logic              unused_lsb;

  logic              m_valid, m_dirty, main_hit;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_line;
  logic              ma_we, ma_dirty;
  logic [LINE_W-1:0] ma_line;

  logic              vb_hit, vb_hit_dirty, vb_ptr_valid, vb_ptr_dirty;
  logic [WAY_W-1:0]  vb_hit_way, vb_ptr_way, vb_way;
  logic [LINE_W-1:0] vb_hit_line, vb_ptr_line;
  logic [BLK_W-1:0]  vb_ptr_blk;
  logic              vb_we, vb_push;

  logic              rsp_set;
  logic [LINE_W-1:0] rsp_line;

  assign unused_lsb = ^req_addr_i[BYTE_W-1:0];
  assign req_blk    = req_addr_i[ADDR_W-1:OFF_W];
  assign look_blk   = (st_q == ST_IDLE) ? req_blk : q_blk;
  assign look_idx   = look_blk[IDX_W-1:0];
  assign look_tag   = look_blk[BLK_W-1:IDX_W];
  assign cur_we     = (st_q == ST_IDLE) ? req_we_i : q_we;
  assign cur_word   = (st_q == ST_IDLE) ? req_addr_i[BYTE_W +: WSEL_W] : q_word;
  assign cur_wdata  = (st_q == ST_IDLE) ? req_wdata_i : q_wdata;
  assign main_hit   = m_valid && (m_tag == look_tag);

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                 input logic [WSEL_W-1:0] w,
                                                 input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = l;
    r[w * DATA_W +: DATA_W] = d;
    return r;
  endfunction

  vc_main_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_main (
    .clk_i, .rst_ni,
    .idx_i     (look_idx),
    .valid_o   (m_valid),
    .dirty_o   (m_dirty),
    .tag_o     (m_tag),
    .line_o    (m_line),
    .wr_en_i   (ma_we),
    .wr_tag_i  (look_tag),
    .wr_line_i (ma_line),
    .wr_dirty_i(ma_dirty)
  );

  vc_victim_buf #(.ENTRIES(VB_ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W)) i_vbuf (
    .clk_i, .rst_ni,
    .look_blk_i (look_blk),
    .hit_o      (vb_hit),
    .hit_way_o  (vb_hit_way),
    .hit_line_o (vb_hit_line),
    .hit_dirty_o(vb_hit_dirty),
    .ptr_way_o  (vb_ptr_way),
    .ptr_valid_o(vb_ptr_valid),
    .ptr_dirty_o(vb_ptr_dirty),
    .ptr_blk_o  (vb_ptr_blk),
    .ptr_line_o (vb_ptr_line),
    .wr_en_i    (vb_we),
    .wr_way_i   (vb_way),
    .wr_valid_i (m_valid),
    .wr_dirty_i (m_dirty),
    .wr_blk_i   ({m_tag, look_idx}),
    .wr_line_i  (m_line),
    .push_i     (vb_push)
  );

  always_comb begin
    st_d        = st_q;
    ma_we       = 1'b0;
    ma_line     = m_line;
    ma_dirty    = 1'b0;
    vb_we       = 1'b0;
    vb_way      = vb_hit_way;
    vb_push     = 1'b0;
    rsp_set     = 1'b0;
    rsp_line    = m_line;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_blk_o   = q_blk;
    mem_wdata_o = vb_ptr_line;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        if (main_hit) begin
          rsp_set  = 1'b1;
          ma_we    = cur_we;
          ma_line  = put_word(m_line, cur_word, cur_wdata);
          ma_dirty = 1'b1;
        end else if (vb_hit) begin
          st_d = ST_SWAP;
        end else if (m_valid && vb_ptr_valid && vb_ptr_dirty) begin
          st_d = ST_WB;
        end else begin
          st_d = ST_FILL;
        end
      end
      ST_SWAP: begin
        // victim line in, displaced main line into the same entry
        ma_we    = 1'b1;
        ma_line  = q_we ? put_word(vb_hit_line, cur_word, cur_wdata) : vb_hit_line;
        ma_dirty = vb_hit_dirty | q_we;
        vb_we    = 1'b1;
        rsp_set  = 1'b1;
        rsp_line = vb_hit_line;
        st_d     = ST_IDLE;
      end
      ST_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        mem_blk_o = vb_ptr_blk;
        if (mem_ack_i) st_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          ma_we    = 1'b1;
          ma_line  = q_we ? put_word(mem_rdata_i, cur_word, cur_wdata) : mem_rdata_i;
          ma_dirty = q_we;
          vb_we    = m_valid;
          vb_way   = vb_ptr_way;
          vb_push  = m_valid;
          rsp_set  = 1'b1;
          rsp_line = mem_rdata_i;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      q_we         <= 1'b0;
      q_blk        <= '0;
      q_word       <= '0;
      q_wdata      <= '0;
      resp_valid_o <= 1'b0;
      resp_rdata_o <= '0;
    end else begin
      st_q         <= st_d;
      resp_valid_o <= rsp_set;
      if (rsp_set) resp_rdata_o <= rsp_line[cur_word * DATA_W +: DATA_W];
      if (st_q == ST_IDLE && req_valid_i) begin
        q_we    <= req_we_i;
        q_blk   <= req_blk;
        q_word  <= req_addr_i[BYTE_W +: WSEL_W];
        q_wdata <= req_wdata_i;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && main_hit) |=> resp_valid_o); // R2
  AST_SWAP_ONE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SWAP) |=> (resp_valid_o && req_ready_o)); // R6
  AST_SINGLE_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_hit && vb_hit)); // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_blk_o))); // R9
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (vb_ptr_valid && vb_ptr_dirty)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !main_hit) |=> !req_ready_o); // R11
endmodule

// File: tb/test_victim_cache.sv
`timescale 1ns/1ps
module test_victim_cache;
  localparam int SETS = 256;
  localparam int VB   = 4;
  localparam int LAT  = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready_o, resp_valid_o, mem_req_o, mem_we_o;
  logic [31:0]  resp_rdata_o;
  logic [27:0]  mem_blk_o;
  logic [127:0] mem_wdata_o;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  victim_cache i_victim_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid_o), .resp_rdata_o(resp_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_blk_o(mem_blk_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  typedef struct { int blk; bit [127:0] line; bit dirty; } vent_t;
  typedef struct { bit we; int blk; bit [127:0] line; } mop_t;

  bit [127:0] m_line [SETS];
  bit         m_val  [SETS];
  bit         m_dirty[SETS];
  int         m_tag  [SETS];
  vent_t      vq[$];
  mop_t       eq[$];
  bit [127:0] mem_m[int];

  task automatic chk(input string r, input bit ok, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit [127:0] get_mem(input int blk);
    bit [127:0] r;
    if (mem_m.exists(blk)) return mem_m[blk];
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = 32'h5A000000 + (blk << 4) + w;
    return r;
  endfunction

  // behavioural model: expected latency, read word and memory transfers
  task automatic model(input bit we, input int blk, input int w, input bit [31:0] d,
                       output int n, output bit [31:0] rd);
    int idx = blk % SETS;
    int tg  = blk / SETS;
    int vi  = -1;
    vent_t ev;
    if (m_val[idx] && m_tag[idx] == tg) n = 1;
    else begin
      foreach (vq[i]) if (vq[i].blk == blk) vi = i;
      if (vi >= 0) begin
        n = 2;
        ev = vq[vi];
        vq[vi] = '{blk: m_tag[idx]*SETS + idx, line: m_line[idx], dirty: m_dirty[idx]};
        m_line[idx] = ev.line; m_dirty[idx] = ev.dirty;
      end else begin
        n = 1 + LAT;
        if (m_val[idx]) begin
          if (vq.size() == VB) begin
            ev = vq.pop_front();
            if (ev.dirty) begin
              n += LAT + 1;
              eq.push_back('{we: 1'b1, blk: ev.blk, line: ev.line});
              mem_m[ev.blk] = ev.line;
            end
          end
          vq.push_back('{blk: m_tag[idx]*SETS + idx, line: m_line[idx], dirty: m_dirty[idx]});
        end
        eq.push_back('{we: 1'b0, blk: blk, line: get_mem(blk)});
        m_line[idx] = get_mem(blk); m_dirty[idx] = 1'b0;
      end
      m_tag[idx] = tg; m_val[idx] = 1'b1;
    end
    rd = m_line[idx][w*32 +: 32];
    if (we) begin
      m_line[idx][w*32 +: 32] = d;
      m_dirty[idx] = 1'b1;
    end
  endtask

  function automatic int unsigned adr(input int tg, input int idx, input int w);
    return tg*4096 + idx*16 + w*4;
  endfunction

  task automatic acc(input bit we, input int unsigned a, input bit [31:0] d, input string tag);
    int n_exp, n;
    bit [31:0] rd_exp;
    string r;
    model(we, int'(a >> 4), int'((a >> 2) & 3), d, n_exp, rd_exp);
    r = tag;
    if (r == "") r = (n_exp == 1) ? (we ? "R3" : "R2") : (n_exp == 2) ? "R6" :
                     (n_exp == 1 + LAT) ? "R4" : "R8";
    @(negedge clk);
    chk("R11", req_ready_o == 1'b1, req_ready_o, 1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (n == 1 && n_exp > 1) chk("R11", req_ready_o == 1'b0, req_ready_o, 0);
    end while (!resp_valid_o && n < 64);
    chk(r, n == n_exp, n, n_exp);
    if (!we) chk(r, resp_rdata_o == rd_exp, resp_rdata_o, rd_exp);
  endtask

  // next-level memory: fixed latency, checks every transfer against the model
  initial begin
    int cnt = 0;
    bit hold_we;
    logic [27:0] hold_blk;
    mop_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin mem_ack = 1'b0; cnt = 0; end
      else if (mem_ack) begin mem_ack = 1'b0; cnt = 0; end
      else if (mem_req_o) begin
        if (cnt == 0) begin hold_we = mem_we_o; hold_blk = mem_blk_o; end
        else chk("R9", mem_we_o == hold_we && mem_blk_o == hold_blk, mem_blk_o, hold_blk);
        cnt++;
        if (cnt == LAT) begin
          if (eq.size() == 0) chk("R5", 1'b0, mem_blk_o, 0);
          else begin
            e = eq.pop_front();
            chk(e.we ? "R8" : "R4", mem_we_o == e.we && int'(mem_blk_o) == e.blk,
                {mem_we_o, mem_blk_o}, {e.we, e.blk[27:0]});
            if (e.we) chk("R8", mem_wdata_o == e.line, mem_wdata_o[63:0], e.line[63:0]);
          end
          if (!mem_we_o) mem_rdata = get_mem(int'(mem_blk_o));
          mem_ack = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", req_ready_o == 1'b1, req_ready_o, 1);
    chk("R1", resp_valid_o == 1'b0, resp_valid_o, 0);
    chk("R1", mem_req_o == 1'b0, mem_req_o, 0);
    rst_n = 1'b1;
    acc(0, adr(0, 5, 0), 0, "R1");           // cold miss
    acc(0, adr(0, 5, 1), 0, "R2");
    acc(1, adr(0, 5, 2), 32'hDEAD0001, "R3");
    acc(0, adr(0, 5, 2), 0, "R3");
    acc(0, adr(1, 5, 0), 0, "R5");           // evicts dirty line, no write
    acc(0, adr(0, 5, 2), 0, "R5");           // found in buffer
    acc(0, adr(0, 5, 2), 0, "R10");          // now only in main store
    acc(0, adr(1, 5, 3), 0, "R6");
    for (int t = 2; t < 7; t++) acc(1, adr(t, 5, t & 3), 32'h1000 + t, "");
    acc(0, adr(0, 5, 2), 0, "R7");           // oldest entry was pushed out
    acc(0, adr(5, 5, 1), 0, "");
    for (int i = 0; i < 300; i++)
      acc((i % 3) == 0, adr((i * 7) % 6, (i * 3) % 4 + 10, i % 4), 32'h01010101 * i + 32'h77, "");
    repeat (4) @(negedge clk);
    chk("R8", eq.size() == 0, eq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule